// File: doc/BRIEF.md
# Rotate, Shift and Nibble-Swap Flag Unit

This block is the bit-movement slice of an 8-bit processor datapath. It takes one operand byte, a 3-bit operation selector and the current carry flag, and produces the transformed byte together with the four condition flags: zero, subtract, half-carry and carry. The selector picks one of eight moves. There are circular rotates, rotates through the carry, arithmetic shifts, a logical right shift and an exchange of the two nibbles. Each move has its own rule for which bit leaves into the carry and what fills the vacated position.

The unit does not know where the operand came from or where the result goes. Register or memory selection stays with the surrounding decode logic. That logic strobes `valid_i` with a stable operand, selector and carry. One clock later the result and flags appear on the registered outputs together with `valid_o`. When no strobe is given, the outputs keep their last values.

Top module: `rss_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o`, `result_o` and all four flag outputs are 0 until the first strobe.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `valid_i` high, and 0 otherwise.
- R3: Selector 3'd0 rotates left: result = {d[6:0], d[7]}, carry = d[7].
- R4: Selector 3'd1 rotates right: result = {d[0], d[7:1]}, carry = d[0].
- R5: Selector 3'd2 rotates left through carry: result = {d[6:0], carry_i}, carry = d[7].
- R6: Selector 3'd3 rotates right through carry: result = {carry_i, d[7:1]}, carry = d[0].
- R7: Selector 3'd4 shifts left, filling with zero: result = {d[6:0], 1'b0}, carry = d[7].
- R8: Selector 3'd5 shifts right arithmetically: result = {d[7], d[7:1]}, carry = d[0].
- R9: Selector 3'd6 exchanges nibbles: result = {d[3:0], d[7:4]}, carry = 0.
- R10: Selector 3'd7 shifts right logically: result = {1'b0, d[7:1]}, carry = d[0].
- R11: For every selector, `flag_z_o` is 1 exactly when the result byte is 0, and `flag_n_o` and `flag_h_o` are 0.
- R12: In a cycle with `valid_i` low, changes on `operand_i`, `op_i` and `carry_i` have no effect: result and flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; captures an operation |
| op_i | input | 3 | Operation selector (0..7) |
| operand_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid, one cycle after strobe |
| result_o | output | 8 | Transformed byte |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Subtract flag (always 0) |
| flag_h_o | output | 1 | Half-carry flag (always 0) |
| flag_c_o | output | 1 | Carry flag out |

## Verification
The result, all four flags and `valid_o` are due exactly one rising edge after the edge that sees `valid_i` high. No other path has a different latency. The bench drives inputs on the falling edge and drops the strobe on the next falling edge. It reads every output on that same falling edge, half a period after the capturing edge and before any further edge. The hold check then changes the idle inputs. It reads the outputs one full cycle later to confirm that nothing moved.

// File: rtl/rss_pkg.sv
package rss_pkg;
  // Selector encoding matches the opcode field order of the enclosing decoder
  typedef enum logic [2:0] {
    RSS_ROL  = 3'd0,
    RSS_ROR  = 3'd1,
    RSS_RCL  = 3'd2,
    RSS_RCR  = 3'd3,
    RSS_SHL  = 3'd4,
    RSS_SAR  = 3'd5,
    RSS_SWAP = 3'd6,
    RSS_SHR  = 3'd7
  } rss_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rss_flags_t;
endpackage

// File: rtl/rss_nibble_swap.sv
module rss_nibble_swap #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar g = 0; g < HALF_W; g++) begin : g_swap
    assign data_o[g]          = data_i[g + HALF_W];
    assign data_o[g + HALF_W] = data_i[g];
  end
endmodule

// File: rtl/rss_shift_core.sv
module rss_shift_core
  import rss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rss_op_e           op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] data_o,
  output logic              carry_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] swapped;

  rss_nibble_swap #(.DATA_W(DATA_W)) u_swap (
    .data_i (data_i),
    .data_o (swapped)
  );

  // Fill bit entering the vacated position; exit bit leaves into carry
  logic fill_lo, fill_hi;

  always_comb begin
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    unique case (op_i)
      RSS_ROL: fill_lo = data_i[MSB];
      RSS_RCL: fill_lo = carry_i;
      RSS_ROR: fill_hi = data_i[0];
      RSS_RCR: fill_hi = carry_i;
      RSS_SAR: fill_hi = data_i[MSB];
      default: ;
    endcase
  end

  always_comb begin
    data_o  = '0;
    carry_o = 1'b0;
    unique case (op_i)
      RSS_ROL, RSS_RCL, RSS_SHL: begin
        data_o  = {data_i[MSB-1:0], fill_lo};
        carry_o = data_i[MSB];
      end
      RSS_ROR, RSS_RCR, RSS_SAR, RSS_SHR: begin
        data_o  = {fill_hi, data_i[MSB:1]};
        carry_o = data_i[0];
      end
      RSS_SWAP: begin
        data_o  = swapped;
        carry_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rss_flag_gen.sv
module rss_flag_gen
  import rss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  output rss_flags_t        flags_o
);
  always_comb begin
    flags_o.z = ~|result_i;
    flags_o.n = 1'b0;
    flags_o.h = 1'b0;
    flags_o.c = carry_i;
  end
endmodule

// File: rtl/rss_unit.sv
module rss_unit
  import rss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_h_o,
  output logic              flag_c_o
);
  logic [DATA_W-1:0] res_d;
  logic              cy_d;
  rss_flags_t        flags_d, flags_q;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;

  rss_shift_core #(.DATA_W(DATA_W)) u_core (
    .op_i    (rss_op_e'(op_i)),
    .data_i  (operand_i),
    .carry_i (carry_i),
    .data_o  (res_d),
    .carry_o (cy_d)
  );

  rss_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .result_i (res_d),
    .carry_i  (cy_d),
    .flags_o  (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign flag_z_o = flags_q.z;
  assign flag_n_o = flags_q.n;
  assign flag_h_o = flags_q.h;
  assign flag_c_o = flags_q.c;
endmodule

// File: rtl/rss_unit_chk.sv
module rss_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_z_o,
  input logic              flag_n_o,
  input logic              flag_h_o,
  input logic              flag_c_o
);
  localparam int HALF_W = DATA_W / 2;

  assert_strobe_to_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_shl_zero_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=>
      (result_o[0] == 1'b0 && flag_c_o == $past(operand_i[DATA_W-1])));

  assert_swap_nibbles_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |=>
      (result_o == {$past(operand_i[HALF_W-1:0]), $past(operand_i[DATA_W-1:HALF_W])}
       && !flag_c_o));

  assert_zero_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flag_z_o == (result_o == '0)));

  assert_nh_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!flag_n_o && !flag_h_o));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flag_z_o) && $stable(flag_c_o)));
endmodule

bind rss_unit rss_unit_chk #(.DATA_W(DATA_W)) u_rss_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .flag_h_o  (flag_h_o),
  .flag_c_o  (flag_c_o)
);

// File: tb/rss_unit_tb.sv
module rss_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0;
  logic       valid_o;
  logic [7:0] result_o;
  logic       flag_z_o, flag_n_o, flag_h_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rss_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .operand_i, .carry_i,
    .valid_o, .result_o, .flag_z_o, .flag_n_o, .flag_h_o, .flag_c_o
  );

  // Expected {result, z, n, h, c} from the requirement text
  function automatic logic [11:0] model(input logic [2:0] op, input logic [7:0] d, input logic ci);
    logic [7:0] r;
    logic c;
    case (op)
      3'd0: begin r = {d[6:0], d[7]};  c = d[7]; end
      3'd1: begin r = {d[0], d[7:1]};  c = d[0]; end
      3'd2: begin r = {d[6:0], ci};    c = d[7]; end
      3'd3: begin r = {ci, d[7:1]};    c = d[0]; end
      3'd4: begin r = {d[6:0], 1'b0};  c = d[7]; end
      3'd5: begin r = {d[7], d[7:1]};  c = d[0]; end
      3'd6: begin r = {d[3:0], d[7:4]}; c = 1'b0; end
      default: begin r = {1'b0, d[7:1]}; c = d[0]; end
    endcase
    return {r, (r == 8'h00), 1'b0, 1'b0, c};
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual res=%h znhc=%b expected res=%h znhc=%b",
               tag, act[11:4], act[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  function automatic logic [11:0] outs();
    return {result_o, flag_z_o, flag_n_o, flag_h_o, flag_c_o};
  endfunction

  // Strobe one operation at a falling edge, read outputs one cycle later
  task automatic run_op(input string tag, input logic [2:0] op, input logic [7:0] d, input logic ci);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; operand_i = d; carry_i = ci;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(tag, outs(), model(op, d, ci));
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R2: valid_o actual=%b expected=1", valid_o);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 in reset", outs(), 12'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", outs(), 12'h000);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid_o actual=%b expected=0", valid_o);
    end
  endtask

  task automatic t_rotate();
    run_op("R3 rol 0x81", 3'd0, 8'h81, 1'b0);
    run_op("R3 rol 0x40", 3'd0, 8'h40, 1'b1);
    run_op("R4 ror 0x01", 3'd1, 8'h01, 1'b0);
    run_op("R4 ror 0xA4", 3'd1, 8'hA4, 1'b1);
  endtask

  task automatic t_through_carry();
    run_op("R5 rcl cin=1", 3'd2, 8'h80, 1'b1);
    run_op("R5 rcl zero", 3'd2, 8'h80, 1'b0);
    run_op("R6 rcr cin=1", 3'd3, 8'h02, 1'b1);
    run_op("R6 rcr zero", 3'd3, 8'h01, 1'b0);
  endtask

  task automatic t_shifts();
    run_op("R7 shl zero", 3'd4, 8'h80, 1'b1);
    run_op("R7 shl 0x55", 3'd4, 8'h55, 1'b1);
    run_op("R8 sar neg", 3'd5, 8'h81, 1'b0);
    run_op("R8 sar pos", 3'd5, 8'h7E, 1'b1);
    run_op("R10 shr 0x01", 3'd7, 8'h01, 1'b1);
    run_op("R10 shr 0xFF", 3'd7, 8'hFF, 1'b0);
  endtask

  task automatic t_swap();
    run_op("R9 swap 0x3C", 3'd6, 8'h3C, 1'b1);
    run_op("R9 swap 0xF1", 3'd6, 8'hF1, 1'b1);
    run_op("R11 swap zero", 3'd6, 8'h00, 1'b1);
  endtask

  task automatic t_hold();
    logic [11:0] prev;
    run_op("R12 setup", 3'd0, 8'h12, 1'b0);
    prev = outs();
    op_i = 3'd6; operand_i = 8'hFF; carry_i = 1'b1;
    @(negedge clk_i);
    chk("R12 idle hold", outs(), prev);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R2: valid_o actual=%b expected=0", valid_o);
    end
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 8; op++) begin
      run_op("R11 sweep a", 3'(op), 8'hC3, 1'b1);
      run_op("R11 sweep b", 3'(op), 8'h00, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_through_carry();
    t_shifts();
    t_swap();
    t_hold();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule